// File: doc/BRIEF.md
# Ranked Top-N Candidate Selector

The selector receives a parallel set of candidate words on every bunch-crossing clock. Each word carries a valid bit, a 7-bit rank and a payload. It picks the best few candidates by rank and presents them on ordered output slots, with the best one in slot 0. Each chosen candidate's rank is re-encoded through a small translation table on the way out. A winner flag goes back to every source whose candidate won a slot, so each source learns whether its word went forward.

All of this runs in a fixed five-register pipeline, so a result never depends on how many candidates were present. Test software can rewrite the translation table through a simple address, data and write-enable port, but only while the test-mode input is high.

Top module: `topn_selector`

## Requirements
- R1: Every output slot, source index, payload, code and winner flag reflects the inputs sampled at a rising clock edge. It becomes visible just after the fourth rising edge that follows that edge, making five registers in total.
- R2: A candidate whose valid bit is low, or whose rank is 0, never occupies a slot. An unfilled slot shows valid 0, with code, payload and source index all 0.
- R3: When two eligible candidates have equal rank, the one with the lower input index takes the earlier slot. No input appears in more than one slot.
- R4: `win_o[i]` is 1 in exactly the cycle in which input i's candidate sits in an output slot, and 0 otherwise.
- R5: Out of 36 inputs, the up to 4 eligible candidates of highest rank are chosen, where a larger rank is better. They fill slots from slot 0 downward in descending rank, with no gaps.
- R6: A filled slot's code is the translation-table entry addressed by the candidate's rank. After reset, entry r holds the value r, zero-extended to the code width. The slot's payload and source index are those of the chosen input.
- R7: A table write, entry `lut_addr` set to `lut_data`, takes effect at a rising edge where both `test_mode` and `lut_we` are 1. With `test_mode` low, the write request changes nothing.
- R8: While reset is asserted, every slot valid bit and every winner flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 36 | Per-input valid bit |
| in_rank | input | 252 | Per-input rank; input i at bits [7i+6:7i] |
| in_pay | input | 288 | Per-input payload; input i at bits [8i+7:8i] |
| test_mode | input | 1 | Enables table writes |
| lut_we | input | 1 | Table write request |
| lut_addr | input | 7 | Table entry (rank) to write |
| lut_data | input | 8 | Value to write |
| out_vld | output | 4 | Slot valid; bit k is slot k |
| out_code | output | 32 | Translated code; slot k at bits [8k+7:8k] |
| out_pay | output | 32 | Slot payload; slot k at bits [8k+7:8k] |
| out_src | output | 24 | Source input index; slot k at bits [6k+5:6k] |
| win_o | output | 36 | Winner flag per input |

## Verification
The bench targets equal ranks across many inputs. A design that broke ties wrongly, or let one input fill two slots, would show the wrong source index or a duplicated winner set. It also drives valid words of rank 0, invalid words of high rank, and crossings with fewer than four eligible candidates. A design that counted those words, or left junk in empty slots, would raise a slot valid or a winner flag that should be low. Table rewrites in and out of test mode, and a rank of 127 on the last input, expose a design that ignores the write gate or misreads the table at its top address.

// File: rtl/topn_pkg.sv
package topn_pkg;
  // Candidate a beats candidate b: strictly higher rank, or equal rank from a lower input index.
  function automatic logic outranks(input int ra, input int ia, input int rb, input int ib);
    return (ra > rb) || ((ra == rb) && (ia < ib));
  endfunction
endpackage

// File: rtl/topn_capture.sv
module topn_capture #(
  parameter int N_IN   = 36,
  parameter int RANK_W = 7,
  parameter int PAY_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_IN-1:0]                   in_vld,
  input  logic [N_IN-1:0][RANK_W-1:0]       in_rank,
  input  logic [N_IN-1:0][PAY_W-1:0]        in_pay,
  output logic [N_IN-1:0][RANK_W-1:0]       eff_rank,
  output logic [N_IN-1:0][PAY_W-1:0]        pay_q
);
  // Stage 1: an invalid candidate is folded into rank 0, which is never eligible.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_rank <= '0;
      pay_q    <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        eff_rank[i] <= in_vld[i] ? in_rank[i] : '0;
      end
      pay_q <= in_pay;
    end
  end
endmodule

// File: rtl/topn_rank.sv
module topn_rank
  import topn_pkg::*;
#(
  parameter int N_IN   = 36,
  parameter int N_OUT  = 4,
  parameter int RANK_W = 7,
  parameter int PAY_W  = 8,
  localparam int POS_W = $clog2(N_OUT)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_IN-1:0][RANK_W-1:0]       rank_i,
  input  logic [N_IN-1:0][PAY_W-1:0]        pay_i,
  output logic [N_IN-1:0]                   sel_q,
  output logic [N_IN-1:0][POS_W-1:0]        pos_q,
  output logic [N_IN-1:0][RANK_W-1:0]       rank_q,
  output logic [N_IN-1:0][PAY_W-1:0]        pay_q
);
  int unsigned                 ahead [N_IN];
  logic [N_IN-1:0]             sel_c;
  logic [N_IN-1:0][POS_W-1:0]  pos_c;

  // Stage 2: each candidate counts how many others beat it; that count is its slot.
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      ahead[i] = 0;
      for (int j = 0; j < N_IN; j++) begin
        if ((j != i) && outranks(int'(rank_i[j]), j, int'(rank_i[i]), i)) begin
          ahead[i] = ahead[i] + 1;
        end
      end
      sel_c[i] = (rank_i[i] != '0) && (ahead[i] < N_OUT);
      pos_c[i] = POS_W'(ahead[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pos_q  <= '0;
      rank_q <= '0;
      pay_q  <= '0;
    end else begin
      sel_q  <= sel_c;
      pos_q  <= pos_c;
      rank_q <= rank_i;
      pay_q  <= pay_i;
    end
  end

  a_r5_sel_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) <= N_OUT);
endmodule

// File: rtl/topn_scatter.sv
module topn_scatter #(
  parameter int N_IN   = 36,
  parameter int N_OUT  = 4,
  parameter int RANK_W = 7,
  parameter int PAY_W  = 8,
  localparam int POS_W = $clog2(N_OUT),
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_IN-1:0]                   sel_i,
  input  logic [N_IN-1:0][POS_W-1:0]        pos_i,
  input  logic [N_IN-1:0][RANK_W-1:0]       rank_i,
  input  logic [N_IN-1:0][PAY_W-1:0]        pay_i,
  output logic [N_OUT-1:0]                  slot_vld,
  output logic [N_OUT-1:0][IDX_W-1:0]       slot_idx,
  output logic [N_OUT-1:0][RANK_W-1:0]      slot_rank,
  output logic [N_OUT-1:0][PAY_W-1:0]       slot_pay,
  output logic [N_IN-1:0]                   win_q
);
  logic [N_OUT-1:0]              vld_c;
  logic [N_OUT-1:0][IDX_W-1:0]   idx_c;
  logic [N_OUT-1:0][RANK_W-1:0]  rank_c;
  logic [N_OUT-1:0][PAY_W-1:0]   pay_c;

  // Stage 3: route each selected candidate to the slot its position names.
  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      vld_c[k]  = 1'b0;
      idx_c[k]  = '0;
      rank_c[k] = '0;
      pay_c[k]  = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (sel_i[i] && (pos_i[i] == POS_W'(k))) begin
          vld_c[k]  = 1'b1;
          idx_c[k]  = IDX_W'(i);
          rank_c[k] = rank_i[i];
          pay_c[k]  = pay_i[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld  <= '0;
      slot_idx  <= '0;
      slot_rank <= '0;
      slot_pay  <= '0;
      win_q     <= '0;
    end else begin
      slot_vld  <= vld_c;
      slot_idx  <= idx_c;
      slot_rank <= rank_c;
      slot_pay  <= pay_c;
      win_q     <= sel_i;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_slot_chk
    a_r2_nonzero_rank: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld[k] |-> (slot_rank[k] != '0) && win_q[slot_idx[k]]);
    if (k < N_OUT - 1) begin : g_pair
      a_r5_descending: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[k+1] |-> slot_vld[k] && (slot_rank[k] >= slot_rank[k+1]));
      a_r3_tie_order: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[k+1] && (slot_rank[k] == slot_rank[k+1])) |-> (slot_idx[k] < slot_idx[k+1]));
    end
    for (genvar m = k + 1; m < N_OUT; m++) begin : g_uniq
      a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[k] && slot_vld[m]) |-> (slot_idx[k] != slot_idx[m]));
    end
  end
endmodule

// File: rtl/topn_lut.sv
module topn_lut #(
  parameter int N_IN   = 36,
  parameter int N_OUT  = 4,
  parameter int RANK_W = 7,
  parameter int PAY_W  = 8,
  parameter int CODE_W = 8,
  localparam int IDX_W = $clog2(N_IN),
  localparam int DEPTH = 1 << RANK_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              test_mode,
  input  logic                              lut_we,
  input  logic [RANK_W-1:0]                 lut_addr,
  input  logic [CODE_W-1:0]                 lut_data,
  input  logic [N_OUT-1:0]                  slot_vld,
  input  logic [N_OUT-1:0][IDX_W-1:0]       slot_idx,
  input  logic [N_OUT-1:0][RANK_W-1:0]      slot_rank,
  input  logic [N_OUT-1:0][PAY_W-1:0]       slot_pay,
  input  logic [N_IN-1:0]                   win_i,
  output logic [N_OUT-1:0]                  vld_q,
  output logic [N_OUT-1:0][CODE_W-1:0]      code_q,
  output logic [N_OUT-1:0][PAY_W-1:0]       pay_q,
  output logic [N_OUT-1:0][IDX_W-1:0]       idx_q,
  output logic [N_IN-1:0]                   win_q
);
  logic [CODE_W-1:0] mem [DEPTH];
  logic              wr_fire;

  assign wr_fire = test_mode && lut_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= CODE_W'(a);
    end else if (wr_fire) begin
      mem[lut_addr] <= lut_data;
    end
  end

  // Stage 4: translate the rank of each filled slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      code_q <= '0;
      pay_q  <= '0;
      idx_q  <= '0;
      win_q  <= '0;
    end else begin
      for (int k = 0; k < N_OUT; k++) begin
        code_q[k] <= slot_vld[k] ? mem[slot_rank[k]] : '0;
      end
      vld_q <= slot_vld;
      pay_q <= slot_pay;
      idx_q <= slot_idx;
      win_q <= win_i;
    end
  end

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (mem[$past(lut_addr)] == $past(lut_data)));
  a_r7_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_we && !test_mode) |=> (mem[$past(lut_addr)] == $past(mem[lut_addr])));
endmodule

// File: rtl/topn_selector.sv
module topn_selector #(
  parameter int N_IN   = 36,
  parameter int N_OUT  = 4,
  parameter int RANK_W = 7,
  parameter int PAY_W  = 8,
  parameter int CODE_W = 8,
  localparam int POS_W = $clog2(N_OUT),
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             in_vld,
  input  logic [N_IN*RANK_W-1:0]      in_rank,
  input  logic [N_IN*PAY_W-1:0]       in_pay,
  input  logic                        test_mode,
  input  logic                        lut_we,
  input  logic [RANK_W-1:0]           lut_addr,
  input  logic [CODE_W-1:0]           lut_data,
  output logic [N_OUT-1:0]            out_vld,
  output logic [N_OUT*CODE_W-1:0]     out_code,
  output logic [N_OUT*PAY_W-1:0]      out_pay,
  output logic [N_OUT*IDX_W-1:0]      out_src,
  output logic [N_IN-1:0]             win_o
);
  logic [N_IN-1:0][RANK_W-1:0]   s1_rank;
  logic [N_IN-1:0][PAY_W-1:0]    s1_pay;
  logic [N_IN-1:0]               s2_sel;
  logic [N_IN-1:0][POS_W-1:0]    s2_pos;
  logic [N_IN-1:0][RANK_W-1:0]   s2_rank;
  logic [N_IN-1:0][PAY_W-1:0]    s2_pay;
  logic [N_OUT-1:0]              s3_vld;
  logic [N_OUT-1:0][IDX_W-1:0]   s3_idx;
  logic [N_OUT-1:0][RANK_W-1:0]  s3_rank;
  logic [N_OUT-1:0][PAY_W-1:0]   s3_pay;
  logic [N_IN-1:0]               s3_win;
  logic [N_OUT-1:0]              s4_vld;
  logic [N_OUT-1:0][CODE_W-1:0]  s4_code;
  logic [N_OUT-1:0][PAY_W-1:0]   s4_pay;
  logic [N_OUT-1:0][IDX_W-1:0]   s4_idx;
  logic [N_IN-1:0]               s4_win;

  topn_capture #(.N_IN(N_IN), .RANK_W(RANK_W), .PAY_W(PAY_W)) u_capture (
    .clk, .rst_n, .in_vld, .in_rank(in_rank), .in_pay(in_pay),
    .eff_rank(s1_rank), .pay_q(s1_pay));

  topn_rank #(.N_IN(N_IN), .N_OUT(N_OUT), .RANK_W(RANK_W), .PAY_W(PAY_W)) u_rank (
    .clk, .rst_n, .rank_i(s1_rank), .pay_i(s1_pay),
    .sel_q(s2_sel), .pos_q(s2_pos), .rank_q(s2_rank), .pay_q(s2_pay));

  topn_scatter #(.N_IN(N_IN), .N_OUT(N_OUT), .RANK_W(RANK_W), .PAY_W(PAY_W)) u_scatter (
    .clk, .rst_n, .sel_i(s2_sel), .pos_i(s2_pos), .rank_i(s2_rank), .pay_i(s2_pay),
    .slot_vld(s3_vld), .slot_idx(s3_idx), .slot_rank(s3_rank), .slot_pay(s3_pay),
    .win_q(s3_win));

  topn_lut #(.N_IN(N_IN), .N_OUT(N_OUT), .RANK_W(RANK_W), .PAY_W(PAY_W),
             .CODE_W(CODE_W)) u_lut (
    .clk, .rst_n, .test_mode, .lut_we, .lut_addr, .lut_data,
    .slot_vld(s3_vld), .slot_idx(s3_idx), .slot_rank(s3_rank), .slot_pay(s3_pay),
    .win_i(s3_win), .vld_q(s4_vld), .code_q(s4_code), .pay_q(s4_pay),
    .idx_q(s4_idx), .win_q(s4_win));

  // Stage 5: output register; slots and winner flags leave together.
  logic [N_OUT-1:0]              o_vld;
  logic [N_OUT-1:0][CODE_W-1:0]  o_code;
  logic [N_OUT-1:0][PAY_W-1:0]   o_pay;
  logic [N_OUT-1:0][IDX_W-1:0]   o_idx;
  logic [N_IN-1:0]               o_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld  <= '0;
      o_code <= '0;
      o_pay  <= '0;
      o_idx  <= '0;
      o_win  <= '0;
    end else begin
      o_vld  <= s4_vld;
      o_code <= s4_code;
      o_pay  <= s4_pay;
      o_idx  <= s4_idx;
      o_win  <= s4_win;
    end
  end

  assign out_vld  = o_vld;
  assign out_code = o_code;
  assign out_pay  = o_pay;
  assign out_src  = o_idx;
  assign win_o    = o_win;

  a_r4_winner_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(o_win) == $countones(o_vld));
  a_r2_empty_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !o_vld[N_OUT-1] |-> (o_code[N_OUT-1] == '0) && (o_pay[N_OUT-1] == '0));
endmodule

// File: tb/test_topn_selector.sv
module test_topn_selector;
  localparam int CLK_PERIOD = 25;
  localparam int NI = 36;
  localparam int NO = 4;
  localparam int RW = 7;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int IW = 6;
  localparam int LAT = 5;

  typedef struct packed {
    logic [NO-1:0]          vld;
    logic [NO-1:0][CW-1:0]  code;
    logic [NO-1:0][PW-1:0]  pay;
    logic [NO-1:0][IW-1:0]  src;
    logic [NI-1:0]          win;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] tv = '0;
  logic [NI-1:0][RW-1:0] tr = '0;
  logic [NI-1:0][PW-1:0] tp = '0;
  logic test_mode = 1'b0, lut_we = 1'b0;
  logic [RW-1:0] lut_addr = '0;
  logic [CW-1:0] lut_data = '0;
  logic [NO-1:0] out_vld;
  logic [NO*CW-1:0] out_code;
  logic [NO*PW-1:0] out_pay;
  logic [NO*IW-1:0] out_src;
  logic [NI-1:0] win_o;

  int tests = 0, fails = 0, cycles = 0;
  logic [CW-1:0] ref_lut [128];
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  topn_selector i_topn_selector (
    .clk, .rst_n, .in_vld(tv), .in_rank(tr), .in_pay(tp),
    .test_mode, .lut_we, .lut_addr, .lut_data,
    .out_vld, .out_code, .out_pay, .out_src, .win_o);

  // Reference: repeatedly pick the best unused eligible candidate.
  function automatic exp_t model();
    exp_t e = '0;
    bit used [NI];
    for (int i = 0; i < NI; i++) used[i] = 0;
    for (int k = 0; k < NO; k++) begin
      int best = -1;
      for (int i = 0; i < NI; i++) begin
        if (tv[i] && tr[i] != 0 && !used[i]) begin
          if (best < 0) best = i;
          else if (tr[i] > tr[best]) best = i;
        end
      end
      if (best >= 0) begin
        used[best] = 1;
        e.vld[k] = 1'b1;
        e.code[k] = ref_lut[tr[best]];
        e.pay[k] = tp[best];
        e.src[k] = IW'(best);
        e.win[best] = 1'b1;
      end
    end
    return e;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    e = rst_n ? model() : '0;
    q.push_back(e);
    if (q.size() > LAT) void'(q.pop_front());
    if (!rst_n) begin
      for (int a = 0; a < 128; a++) ref_lut[a] = CW'(a);
    end else if (test_mode && lut_we) begin
      ref_lut[lut_addr] = lut_data;
    end
    cycles++;
  end

  always @(negedge clk) begin
    if (q.size() == LAT) begin
      exp_t e;
      e = q[0];
      tests++;
      if (out_vld !== e.vld) begin
        fails++;
        $display("FAIL R1,R2,R5 slot valid act=%h exp=%h", out_vld, e.vld);
      end
      tests++;
      if (out_src !== e.src) begin
        fails++;
        $display("FAIL R3,R5 source index act=%h exp=%h", out_src, e.src);
      end
      tests++;
      if (out_pay !== e.pay) begin
        fails++;
        $display("FAIL R6 payload act=%h exp=%h", out_pay, e.pay);
      end
      tests++;
      if (out_code !== e.code) begin
        fails++;
        $display("FAIL R6,R7 code act=%h exp=%h", out_code, e.code);
      end
      tests++;
      if (win_o !== e.win) begin
        fails++;
        $display("FAIL R4 winner flags act=%h exp=%h", win_o, e.win);
      end
    end
  end

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      tv = '0; tr = '0; tp = '0; lut_we = 1'b0;
    end
  endtask

  task automatic rand_cycles(input int n, input int rmax);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
        tv[i] = ($urandom % 4) != 0;
        tr[i] = RW'($urandom % rmax);
        tp[i] = PW'($urandom);
      end
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;  // R8 reset state
    if (out_vld !== '0 || win_o !== '0) begin
      fails++;
      $display("FAIL R8 reset act=%h/%h exp=0/0", out_vld, win_o);
    end
    rst_n = 1'b1;
    idle(4);
    // R5 R3: random ranks, then a narrow range that forces ties
    rand_cycles(200, 128);
    rand_cycles(200, 4);
    // R3: all equal ranks, lower indices must win
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin tv[i] = 1; tr[i] = 7'd50; tp[i] = PW'(i + 100); end
    // R2: invalid high-rank words and valid rank-0 words only
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin tv[i] = i[0]; tr[i] = i[0] ? 7'd0 : 7'd127; end
    // R2: only two eligible candidates
    @(negedge clk);
    tv = '0; tr = '0;
    tv[9] = 1; tr[9] = 7'd3; tv[30] = 1; tr[30] = 7'd90;
    // R5 R6: maximum rank at the last input
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin tv[i] = 1; tr[i] = 7'd1; end
    tr[NI-1] = 7'd127;
    idle(LAT + 1);
    // R7: writes in test mode
    for (int a = 120; a < 128; a++) begin
      @(negedge clk);
      test_mode = 1; lut_we = 1; lut_addr = RW'(a); lut_data = CW'(255 - a);
    end
    @(negedge clk);
    lut_addr = 7'd50; lut_data = 8'hA5;
    @(negedge clk);
    lut_we = 0; test_mode = 0;
    idle(LAT + 1);
    rand_cycles(150, 128);
    idle(LAT + 1);
    // R7: write request with test mode low must leave entry 60 unchanged
    @(negedge clk);
    lut_we = 1; lut_addr = 7'd60; lut_data = 8'h11;
    idle(LAT + 1);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin tv[i] = 1; tr[i] = (i < 3) ? 7'd60 : 7'd50; end
    idle(LAT + 2);
    summary();
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    tests++;
    $display("FAIL watchdog expired act=%0d exp<20000 cycles", cycles);
    summary();
  end
endmodule